// File: doc/BRIEF.md
# Audio Port Clock Divider

This block derives the two timing signals of a serial audio port, the bit clock and the left/right frame clock, from a single master clock. A 3-bit ratio code picks how many master clock cycles make up one sample period. The bit clock always runs at 64 cycles per sample, so the master clock is divided by the ratio over 64. The frame clock spends 32 bit-clock periods in each half. The transmit and receive sides are separate copies. Each copy has its own ratio code and its own direction bit, which chooses between driving the clocks and leaving the pins to an external source.

A format checker also looks at the selected sample width together with the justification mode. It raises a registered error flag for a combination that cannot be framed, and for the reserved ratio code. The reserved code is run as a 256 ratio. The surrounding control logic holds the configuration inputs and drives the pads from the clock outputs and their enables.

Top module: `afc_clock_gen`

## Requirements
- R1: In drive mode, ratio codes 000 to 110 give master-clock ratios of 128, 192, 256, 384, 512, 768 and 1152. The bit clock period is the ratio divided by 64 (2, 3, 4, 6, 8, 12 or 18 master cycles). The bit clock is high for the first floor(period/2) cycles of each period.
- R2: The frame clock starts low after a restart and inverts on every 32nd falling edge of the bit clock. Its period is therefore exactly the ratio in master cycles.
- R3: The frame clock only changes in a cycle where the bit clock falls, except at a restart.
- R4: With the direction bit at 0 (follow mode), that side's enable output is 0 and its bit and frame clock outputs stay at 0.
- R5: With the direction bit at 1 (drive mode), that side's enable output is 1.
- R6: Transmit and receive sides run independently from their own code and direction bit.
- R7: Ratio code 111 runs that side at the 256 ratio (bit clock period 4). It sets the error output one master cycle later.
- R8: Width code 00/01/10/11 means 16/20/24/32 bits. Width code 11 together with right justification (right_just = 1) sets the error output one cycle later. Every other width and justification pairing leaves it clear.
- R9: A change of a side's ratio code or direction bit restarts that side. At the first edge after the change the counters clear, the bit clock goes high and the frame clock goes low.
- R10: During reset the error output is 0 and a side in drive mode shows the bit clock high and the frame clock low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_ratio | input | 3 | Transmit ratio code |
| tx_master | input | 1 | Transmit direction: 1 drive, 0 follow |
| rx_ratio | input | 3 | Receive ratio code |
| rx_master | input | 1 | Receive direction: 1 drive, 0 follow |
| word_len | input | 2 | Sample width code |
| right_just | input | 1 | 1 selects right-justified format |
| tx_bclk | output | 1 | Transmit bit clock |
| tx_lrclk | output | 1 | Transmit frame clock |
| tx_clk_oe | output | 1 | Pad enable for transmit clocks |
| rx_bclk | output | 1 | Receive bit clock |
| rx_lrclk | output | 1 | Receive frame clock |
| rx_clk_oe | output | 1 | Pad enable for receive clocks |
| cfg_error | output | 1 | Registered configuration error flag |

## Verification
The bench sweeps every ratio code on both sides at once and compares each master cycle against arithmetic models of the two clocks. The odd divide (ratio 192) and the 1152 ratio are the cases most likely to expose a bad high/low split or an off-by-one in the frame clock, and they would show up as a drifting frame edge. The reserved code is checked for running at the 256 ratio rather than stalling or taking a stray divide. All eight width and justification pairings are checked, so a flag raised for the wrong pairing is caught. Direction changes check that a side in follow mode drives nothing, and that re-entering drive mode restarts the frame clock low instead of resuming mid-frame.

// File: rtl/afc_pkg.sv
// Shared types and constants for the audio port clock divider.
// Assumes a 64-cycle-per-sample bit clock with 32 bits per channel half.
package afc_pkg;
    localparam int RATIO_W   = 3;
    localparam int DIV_W     = 5;
    localparam int BITS_HALF = 32;

    typedef enum logic [1:0] {
        WL_16 = 2'b00,
        WL_20 = 2'b01,
        WL_24 = 2'b10,
        WL_32 = 2'b11
    } afc_width_e;

    typedef enum logic [RATIO_W-1:0] {
        RT_128  = 3'b000,
        RT_192  = 3'b001,
        RT_256  = 3'b010,
        RT_384  = 3'b011,
        RT_512  = 3'b100,
        RT_768  = 3'b101,
        RT_1152 = 3'b110,
        RT_RSVD = 3'b111
    } afc_ratio_e;
endpackage

// File: rtl/afc_ratio_decode.sv
// Maps a ratio code to the bit clock divide (ratio / 64) and the length of
// the high phase. Assumes the reserved code is handled as the 256 ratio;
// it is flagged on the reserved output.
module afc_ratio_decode
    import afc_pkg::*;
#(
    parameter int CODE_W = RATIO_W,
    parameter int DW     = DIV_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [DW-1:0]     div,
    output logic [DW-1:0]     half,
    output logic              reserved
);
    // Table lookup of the divide for each ratio code.
    always_comb begin
        reserved = 1'b0;
        unique case (afc_ratio_e'(code))
            RT_128:  div = DW'(2);
            RT_192:  div = DW'(3);
            RT_256:  div = DW'(4);
            RT_384:  div = DW'(6);
            RT_512:  div = DW'(8);
            RT_768:  div = DW'(12);
            RT_1152: div = DW'(18);
            default: begin
                div      = DW'(4);
                reserved = 1'b1;
            end
        endcase
    end

    // The high phase is the lower half of an odd divide.
    assign half = div >> 1;
endmodule

// File: rtl/afc_fmt_check.sv
// Flags a sample width that cannot be framed in the chosen justification.
// Assumes the width and justification inputs are static between checks.
module afc_fmt_check
    import afc_pkg::*;
(
    input  logic [1:0] word_len,
    input  logic       right_just,
    output logic       bad
);
    // Widest sample is not available when right justified.
    always_comb begin
        bad = (afc_width_e'(word_len) == WL_32) && right_just;
    end
endmodule

// File: rtl/afc_clk_div.sv
// One side of the port: divides the master clock into a bit clock and a
// frame clock. Assumes div >= 2 and half = floor(div/2). Any change of the
// direction bit or ratio code restarts the counters; follow mode holds them
// in restart and drives zeros.
module afc_clk_div
    import afc_pkg::*;
#(
    parameter int CODE_W = RATIO_W,
    parameter int DW     = DIV_W,
    parameter int HALF_B = BITS_HALF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master,
    input  logic [CODE_W-1:0] code,
    input  logic [DW-1:0]     div,
    input  logic [DW-1:0]     half,
    output logic              bclk_o,
    output logic              lrclk_o
);
    localparam int BW = (HALF_B > 1) ? $clog2(HALF_B) : 1;
    localparam logic [BW-1:0] BIT_LAST = BW'(HALF_B - 1);

    logic [DW-1:0]     cnt_q, cnt_nx;
    logic [BW-1:0]     bit_q;
    logic              bclk_q, lr_q;
    logic [CODE_W:0]   cfg_q;
    logic              restart, fall;

    // Restart when in follow mode or when the configuration moved.
    assign restart = !master || ({master, code} != cfg_q);

    // Next master-cycle position and whether the bit clock falls there.
    always_comb begin
        cnt_nx = (cnt_q >= div - DW'(1)) ? '0 : cnt_q + DW'(1);
        fall   = (cnt_nx == half);
    end

    // Remember the configuration seen at the last edge.
    always_ff @(posedge clk) begin
        cfg_q <= {master, code};
    end

    // Divide counter, bit clock, bit counter and frame clock.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q  <= '0;
            bclk_q <= 1'b1;
            bit_q  <= '0;
            lr_q   <= 1'b0;
        end else begin
            cnt_q  <= cnt_nx;
            bclk_q <= (cnt_nx < half);
            if (fall) begin
                bit_q <= (bit_q == BIT_LAST) ? '0 : bit_q + BW'(1);
                if (bit_q == BIT_LAST) begin
                    lr_q <= ~lr_q;
                end
            end
        end
    end

    // Only drive the clocks in drive mode.
    assign bclk_o  = master & bclk_q;
    assign lrclk_o = master & lr_q;

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (cnt_q < div));

    assert_rise_at_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk_q) |-> (cnt_q == '0));

    assert_frame_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(lr_q) && !$past(restart)) |-> $fell(bclk_q));

    assert_follow_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !master |=> (cnt_q == '0 && !lr_q && bit_q == '0));
endmodule

// File: rtl/afc_clock_gen.sv
// Top of the audio port clock divider: a transmit and a receive side, each
// with its own ratio code and direction bit, plus a registered error flag
// for the reserved ratio code or an unframeable width. Assumes the pads are
// driven from the clock outputs under their enables.
module afc_clock_gen
    import afc_pkg::*;
#(
    parameter int NSIDE = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   tx_ratio,
    input  logic         tx_master,
    input  logic [2:0]   rx_ratio,
    input  logic         rx_master,
    input  logic [1:0]   word_len,
    input  logic         right_just,
    output logic         tx_bclk,
    output logic         tx_lrclk,
    output logic         tx_clk_oe,
    output logic         rx_bclk,
    output logic         rx_lrclk,
    output logic         rx_clk_oe,
    output logic         cfg_error
);
    logic [RATIO_W-1:0] code_a   [NSIDE];
    logic               mst_a    [NSIDE];
    logic [DIV_W-1:0]   div_a    [NSIDE];
    logic [DIV_W-1:0]   half_a   [NSIDE];
    logic [NSIDE-1:0]   rsvd_v;
    logic               bclk_a   [NSIDE];
    logic               lr_a     [NSIDE];
    logic               fmt_bad;
    logic               err_q;

    // Side 0 is transmit, side 1 is receive.
    always_comb begin
        code_a[0] = tx_ratio;
        code_a[1] = rx_ratio;
        mst_a[0]  = tx_master;
        mst_a[1]  = rx_master;
    end

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        afc_ratio_decode #(.CODE_W(RATIO_W), .DW(DIV_W)) u_dec (
            .code     (code_a[g]),
            .div      (div_a[g]),
            .half     (half_a[g]),
            .reserved (rsvd_v[g])
        );

        afc_clk_div #(.CODE_W(RATIO_W), .DW(DIV_W), .HALF_B(BITS_HALF)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .master  (mst_a[g]),
            .code    (code_a[g]),
            .div     (div_a[g]),
            .half    (half_a[g]),
            .bclk_o  (bclk_a[g]),
            .lrclk_o (lr_a[g])
        );
    end

    afc_fmt_check u_fmt (
        .word_len   (word_len),
        .right_just (right_just),
        .bad        (fmt_bad)
    );

    // Register the combined configuration error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= (|rsvd_v) | fmt_bad;
        end
    end

    assign tx_bclk   = bclk_a[0];
    assign tx_lrclk  = lr_a[0];
    assign tx_clk_oe = tx_master;
    assign rx_bclk   = bclk_a[1];
    assign rx_lrclk  = lr_a[1];
    assign rx_clk_oe = rx_master;
    assign cfg_error = err_q;

    assert_reserved_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ratio == 3'b111 || rx_ratio == 3'b111) |=> cfg_error);

    assert_width_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_len == 2'b11 && right_just) |=> cfg_error);

    assert_clean_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ratio != 3'b111 && rx_ratio != 3'b111 && !(word_len == 2'b11 && right_just))
        |=> !cfg_error);
endmodule

// File: tb/afc_clock_gen_test.sv
module afc_clock_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] tx_ratio = 3'b010, rx_ratio = 3'b010;
    logic       tx_master = 1'b1, rx_master = 1'b0;
    logic [1:0] word_len = 2'b10;
    logic       right_just = 1'b0;
    logic       tx_bclk, tx_lrclk, tx_clk_oe, rx_bclk, rx_lrclk, rx_clk_oe, cfg_error;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    afc_clock_gen uut (
        .clk(clk), .rst_n(rst_n),
        .tx_ratio(tx_ratio), .tx_master(tx_master),
        .rx_ratio(rx_ratio), .rx_master(rx_master),
        .word_len(word_len), .right_just(right_just),
        .tx_bclk(tx_bclk), .tx_lrclk(tx_lrclk), .tx_clk_oe(tx_clk_oe),
        .rx_bclk(rx_bclk), .rx_lrclk(rx_lrclk), .rx_clk_oe(rx_clk_oe),
        .cfg_error(cfg_error)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int div_of(input int code);
        case (code)
            0: return 2;  1: return 3;  2: return 4;  3: return 6;
            4: return 8;  5: return 12; 6: return 18; default: return 4;
        endcase
    endfunction

    // Bit clock k cycles after a restart.
    function automatic int exp_b(input int k, input int d);
        return ((k % d) < (d / 2)) ? 1 : 0;
    endfunction

    // Frame clock: inverts on every 32nd bit clock fall.
    function automatic int exp_l(input int k, input int d);
        int nf;
        nf = (k >= d / 2) ? ((k - d / 2) / d + 1) : 0;
        return (nf / 32) % 2;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10", "err in reset", cfg_error, 0);
        check("R10", "tx bclk in reset", tx_bclk, 1);
        check("R10", "tx lrclk in reset", tx_lrclk, 0);
        check("R5", "tx oe drive", tx_clk_oe, 1);
        check("R4", "rx oe follow", rx_clk_oe, 0);
        rst_n = 1'b1;

        // R6, R4: tx driving at code 000 while rx follows
        tx_ratio = 3'b000;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            check("R6", "tx bclk with rx idle", tx_bclk, exp_b(k, 2));
            check("R6", "tx lrclk with rx idle", tx_lrclk, exp_l(k, 2));
            check("R4", "rx bclk follow", rx_bclk, 0);
            check("R4", "rx lrclk follow", rx_lrclk, 0);
        end

        // R1 R2 R7 R9: sweep all codes on both sides at once
        for (int c = 0; c < 8; c++) begin
            int rc, dt, dr, len;
            rc = (c == 7) ? 7 : 6 - c;
            dt = div_of(c);
            dr = div_of(rc);
            tx_master = 1'b0;
            rx_master = 1'b0;
            @(negedge clk);
            check("R4", "tx oe follow", tx_clk_oe, 0);
            check("R4", "tx bclk follow", tx_bclk, 0);
            check("R4", "rx bclk follow", rx_bclk, 0);
            tx_master = 1'b1;
            rx_master = 1'b1;
            tx_ratio = 3'(c);
            rx_ratio = 3'(rc);
            len = 2 * 64 * ((dt > dr) ? dt : dr) + 4;
            for (int k = 0; k < len; k++) begin
                @(negedge clk);
                if (k == 0) begin
                    check("R7", "err after code", cfg_error, (c == 7) ? 1 : 0);
                    check("R5", "rx oe drive", rx_clk_oe, 1);
                end
                check("R1", $sformatf("tx bclk code %0d k %0d", c, k), tx_bclk, exp_b(k, dt));
                check("R2", $sformatf("tx lrclk code %0d k %0d", c, k), tx_lrclk, exp_l(k, dt));
                check("R1", $sformatf("rx bclk code %0d k %0d", rc, k), rx_bclk, exp_b(k, dr));
                check("R2", $sformatf("rx lrclk code %0d k %0d", rc, k), rx_lrclk, exp_l(k, dr));
            end
        end

        // R9: code change without leaving drive mode restarts mid-frame
        tx_ratio = 3'b011;
        rx_ratio = 3'b011;
        repeat (200) @(negedge clk);
        tx_ratio = 3'b100;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            check("R9", "tx bclk after code change", tx_bclk, exp_b(k, 8));
            check("R9", "tx lrclk after code change", tx_lrclk, exp_l(k, 8));
        end

        // R8: every width and justification pairing
        tx_ratio = 3'b010;
        rx_ratio = 3'b010;
        for (int w = 0; w < 4; w++) begin
            for (int j = 0; j < 2; j++) begin
                word_len = 2'(w);
                right_just = 1'(j);
                @(negedge clk);
                check("R8", $sformatf("err width %0d rj %0d", w, j), cfg_error,
                      (w == 3 && j == 1) ? 1 : 0);
            end
        end

        // R7: reserved code on receive side alone
        word_len = 2'b10;
        right_just = 1'b0;
        rx_ratio = 3'b111;
        @(negedge clk);
        check("R7", "err rx reserved", cfg_error, 1);
        rx_ratio = 3'b001;
        @(negedge clk);
        check("R7", "err cleared", cfg_error, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule